// File: doc/BRIEF.md
# Presettable Up/Down Binary Counter Stage

A small synchronous binary counter, four bits wide by default, that steps up or down by one on each rising clock edge while it is enabled. A low level on its load input writes the preset bus into the count straight away, without waiting for a clock edge, and takes priority over every other input. Counting wraps in both directions.

Two outputs let several stages be chained into a wider counter. The end flag `at_end` marks the last value in the current direction: all ones when counting up, zero when counting down. It feeds look-ahead gating into the next stage's enable. The active-low ripple output `ripple_n` falls only during the low half of the clock, and only when the end flag is high and the stage is enabled. That low pulse can clock or enable a following stage in a rippled chain.

The direction and enable inputs are meant to change only while the clock is high.

Top module: `updown_cnt_stage`

## Requirements
- R1: While `ld_n` is 0, `q` equals `preset` at once, with no clock edge needed. A rising clock edge while `ld_n` is 0 leaves `q` at `preset`, whatever `cnt_en_n` and `down` are.
- R2: With `ld_n` 1 and `cnt_en_n` 1, `q` keeps its value across clock edges.
- R3: With `ld_n` 1, `cnt_en_n` 0 and `down` 0, each rising edge adds one to `q`. The value all ones wraps to 0.
- R4: With `ld_n` 1, `cnt_en_n` 0 and `down` 1, each rising edge subtracts one from `q`. The value 0 wraps to all ones.
- R5: `at_end` is 1 exactly when `down` is 0 and `q` is all ones, or when `down` is 1 and `q` is 0. It follows a change of `down` with no clock edge.
- R6: `ripple_n` is 0 exactly when `at_end` is 1, `cnt_en_n` is 0 and `clk` is 0. It is 1 in every other case, including the whole high phase of the clock.
- R7: After `ld_n` returns to 1, the first qualifying rising edge counts on from the loaded value.
- R8: Two stages chained, with the upper stage's `cnt_en_n` driven by the inverse of the lower stage's `at_end`, form a wider counter. It wraps correctly across the all-ones/zero boundary in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the count changes on the rising edge |
| ld_n | input | 1 | Asynchronous load, active low |
| preset | input | WIDTH | Value written into the count during a load |
| cnt_en_n | input | 1 | Count enable, active low |
| down | input | 1 | Direction: 0 counts up, 1 counts down |
| q | output | WIDTH | Current count |
| at_end | output | 1 | End flag for the current direction |
| ripple_n | output | 1 | Active-low cascade pulse during the clock-low phase at the end value |

## Verification
The hardest situation to reach is the end flag changing with no clock edge: the count must sit exactly at all ones or zero while the direction flips. The stimulus parks the count at 15 by a directed load-and-count sequence, then toggles `down` in the clock-high phase, where both `at_end` and `ripple_n` are observed. Seeded random cycles then mix loads held across an edge, inhibit cycles and direction changes. A two-stage chain is loaded near 255 and walked across the 8-bit wrap both ways.

// File: rtl/updown_cnt_stage.sv
module updown_cnt_stage #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             ld_n,
  input  logic [WIDTH-1:0] preset,
  input  logic             cnt_en_n,
  input  logic             down,
  output logic [WIDTH-1:0] q,
  output logic             at_end,
  output logic             ripple_n
);
  localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] cnt;

  always_ff @(posedge clk or negedge ld_n) begin
    if (!ld_n)
      cnt <= preset;
    else if (!cnt_en_n)
      cnt <= down ? cnt - ONE : cnt + ONE;
  end

  assign q        = ld_n ? cnt : preset;
  assign at_end   = down ? (q == '0) : (q == TOP);
  assign ripple_n = ~(at_end & ~cnt_en_n & ~clk);

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!ld_n)
    cnt_en_n |=> $stable(q));
  // R3
  up_step_chk: assert property (@(posedge clk) disable iff (!ld_n)
    (!cnt_en_n && !down) |=> q == $past(q) + ONE);
  // R4
  down_step_chk: assert property (@(posedge clk) disable iff (!ld_n)
    (!cnt_en_n && down) |=> q == $past(q) - ONE);
  // R5
  end_wrap_chk: assert property (@(posedge clk) disable iff (!ld_n)
    (!cnt_en_n && at_end) |=> (q == ($past(down) ? TOP : '0)));
  // R6
  rc_idle_chk: assert property (@(negedge clk) disable iff (!ld_n)
    ripple_n);
endmodule

// File: tb/updown_cnt_stage_test.sv
module updown_cnt_stage_test;
  logic clk = 0;
  always #5 clk = ~clk;

  logic       ld_n = 0, cnt_en_n = 1, down = 0;
  logic [3:0] preset = 4'd13;
  logic [3:0] q;
  logic       at_end, ripple_n;

  updown_cnt_stage #(.WIDTH(4)) uut (.clk(clk), .ld_n(ld_n), .preset(preset),
    .cnt_en_n(cnt_en_n), .down(down), .q(q), .at_end(at_end), .ripple_n(ripple_n));

  logic       c_ld = 0, c_dn = 0;
  logic [7:0] c_p = 8'd250;
  logic [3:0] lo_q, hi_q;
  logic       lo_end, hi_end, lo_rn, hi_rn;

  updown_cnt_stage #(.WIDTH(4)) chain_lo (.clk(clk), .ld_n(c_ld), .preset(c_p[3:0]),
    .cnt_en_n(1'b0), .down(c_dn), .q(lo_q), .at_end(lo_end), .ripple_n(lo_rn));
  updown_cnt_stage #(.WIDTH(4)) chain_hi (.clk(clk), .ld_n(c_ld), .preset(c_p[7:4]),
    .cnt_en_n(~lo_end), .down(c_dn), .q(hi_q), .at_end(hi_end), .ripple_n(hi_rn));

  int checks = 0, fails = 0;
  logic [3:0] exp_q;
  logic [7:0] c_exp;
  bit done = 0;

  function automatic logic [3:0] next_val(logic [3:0] v, logic dn);
    return dn ? v - 4'd1 : v + 4'd1;
  endfunction
  function automatic logic end_val(logic [3:0] v, logic dn);
    return dn ? (v == 4'd0) : (v == 4'd15);
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
    end
  endtask

  // called at posedge+1: apply inputs, check, run through one clock edge
  task automatic cyc(logic l, logic [3:0] p, logic ce, logic dn);
    ld_n = l; preset = p; cnt_en_n = ce; down = dn;
    #1;
    if (!l) exp_q = p;
    chk(l ? "R2/R3/R4" : "R1", {4'd0, q}, {4'd0, exp_q});
    chk("R5", {7'd0, at_end}, {7'd0, end_val(exp_q, dn)});
    chk("R6 high phase", {7'd0, ripple_n}, 8'd1);
    @(negedge clk); #2;
    chk("R6 low phase", {7'd0, ripple_n}, {7'd0, !(end_val(exp_q, dn) && !ce)});
    @(posedge clk); #1;
    if (!l) exp_q = p;
    else if (!ce) exp_q = next_val(exp_q, dn);
  endtask

  initial begin
    #2;
    chk("R1 reset state", {4'd0, q}, 8'd13);
    exp_q = 4'd13;
    @(posedge clk); #1;
    // directed sequence: load 13, up 14 15 0 1 2, inhibit, down 1 0 15 14 13
    cyc(1, 0, 0, 0);
    chk("R7", {4'd0, q}, 8'd14);
    cyc(1, 0, 0, 0);
    chk("R3", {4'd0, q}, 8'd15);
    cyc(1, 0, 0, 0);
    chk("R3 wrap", {4'd0, q}, 8'd0);
    repeat (2) cyc(1, 0, 0, 0);
    chk("R3", {4'd0, q}, 8'd2);
    repeat (2) cyc(1, 0, 1, 0);
    chk("R2", {4'd0, q}, 8'd2);
    repeat (2) cyc(1, 0, 0, 1);
    chk("R4", {4'd0, q}, 8'd0);
    cyc(1, 0, 0, 1);
    chk("R4 wrap", {4'd0, q}, 8'd15);
    repeat (2) cyc(1, 0, 0, 1);
    chk("R4", {4'd0, q}, 8'd13);
    // end flag follows direction at 15 with no edge
    cyc(0, 4'd15, 1, 0);
    cyc(1, 0, 1, 0);
    chk("R5 up at 15", {7'd0, at_end}, 8'd1);
    down = 1; #1;
    chk("R5 flip at 15", {7'd0, at_end}, 8'd0);
    chk("R6 flip at 15", {7'd0, ripple_n}, 8'd1);
    down = 0; #1;
    chk("R5 back at 15", {7'd0, at_end}, 8'd1);
    @(posedge clk); #1;
    // asynchronous load in the clock-low phase, overriding enable
    @(negedge clk); #2;
    ld_n = 0; preset = 4'd6; cnt_en_n = 0; #1;
    chk("R1 async", {4'd0, q}, 8'd6);
    @(posedge clk); #1;
    chk("R1 override", {4'd0, q}, 8'd6);
    exp_q = 4'd6;
    cyc(1, 0, 0, 0);
    chk("R7 after load", {4'd0, q}, 8'd7);
    // seeded random mix
    void'($urandom(32'd1234));
    for (int i = 0; i < 400; i++) begin
      logic l;
      l = ($urandom % 8) != 0;
      cyc(l, 4'($urandom), 1'(($urandom % 4) == 0), 1'($urandom));
    end
    // cascade
    c_ld = 0; c_p = 8'd250; c_dn = 0;
    @(posedge clk); #1;
    c_ld = 1; c_exp = 8'd250; #1;
    chk("R8 load", {hi_q, lo_q}, c_exp);
    for (int i = 0; i < 12; i++) begin
      @(posedge clk); #2;
      c_exp = c_exp + 8'd1;
      chk("R8 up", {hi_q, lo_q}, c_exp);
    end
    c_dn = 1;
    for (int i = 0; i < 24; i++) begin
      @(posedge clk); #2;
      c_exp = c_exp - 8'd1;
      chk("R8 down", {hi_q, lo_q}, c_exp);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule